// File: doc/BRIEF.md
# Glitch-free PWM generator with period-aligned duty update

This block produces a pulse-width-modulated output with a fixed period of 2^CNT_W clock cycles (256 at the default width). An internal up-counter runs from 0 to its maximum and wraps. A latched duty value is compared against the zero-extended count. The output is high while the duty value is strictly greater than the count. The duty value is one bit wider than the counter, so the output can sit constantly low (duty 0) or constantly high (duty 256).

A new duty value is captured only in the cycle in which the counter holds its maximum. A change on the duty input therefore never cuts a period short or stretches it; it takes effect from the next period onward. The result of the compare is registered before it leaves the block, so any combinational glitches in the magnitude compare never reach the pin. The output lags the compare by one clock.

Inside the block, the counter is driven by a two-bit operation code: 00 hold, 01 load, 10 increment, 11 clear. The top level uses increment while enabled and clear while disabled. The running count is also brought out as a port.

Top module: `pwm_gen`

## Requirements
- R1: While en_i is high, count_o increases by one on every clock and wraps from 255 to 0, giving a period of 256 cycles.
- R2: While en_i is low, count_o is 0 from the first clock after en_i falls. After en_i rises again, counting resumes at 1 on the next clock.
- R3: In the cycle after the counter holds value c, pwm_o is 1 exactly when the latched duty value is greater than c. The count is zero-extended by one leading 0 for this compare, and the compare result passes through one register.
- R4: Over one full period, the number of cycles with pwm_o high equals the latched duty value. Duty 0 gives pwm_o low on every cycle, and duty 256 gives pwm_o high on every cycle.
- R5: duty_i is captured only on the clock edge at which the count is 255. A change on duty_i at any other point has no effect on pwm_o until the period that starts at count 0 after that capture.
- R6: A duty_i value above 256 is captured as 256, so pwm_o is high for the whole period.
- R7: While rst_ni is low, count_o, the latched duty value and pwm_o are all 0, and this takes effect without waiting for a clock edge.
- R8: After reset is released, the first period uses a duty value of 0, whatever is on duty_i. The value on duty_i first shapes pwm_o in the period that follows the first count of 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; when low, the counter is cleared |
| duty_i | input | CNT_W+1 | Requested duty value, 0 to 2^CNT_W |
| pwm_o | output | 1 | Registered PWM output |
| count_o | output | CNT_W | Current counter value |

## Verification
On every cycle, the bound checker confirms several things. It checks the count step and wrap while enabled and the clear while disabled. It checks that pwm_o equals the previous cycle's compare of latched duty against the count, and that the latched duty only moves after a count of 255. It also checks that the latched duty never exceeds 256. What the checker cannot show is the effect over whole periods. The directed scenarios measure the high time per period for duty values 0, 64, 255, 256 and an over-range value. They show that a mid-period duty change leaves the rest of that period on the old value. They also confirm that the first period after reset ignores the duty input, and that an asynchronous reset forces the outputs low at once.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'b00,
    CNT_LOAD = 2'b01,
    CNT_INC  = 2'b10,
    CNT_CLR  = 2'b11
  } cnt_op_e;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case (op_i)
        CNT_HOLD: cnt_q <= cnt_q;
        CNT_LOAD: cnt_q <= ld_val_i;
        CNT_INC:  cnt_q <= cnt_q + 1'b1;
        default:  cnt_q <= '0;
      endcase
    end
  end

  assign cnt_o    = cnt_q;
  // equality detect marks the last count of a period
  assign at_max_o = (cnt_q == {CNT_W{1'b1}});
endmodule

// File: rtl/pwm_duty_latch.sv
module pwm_duty_latch #(
  parameter int unsigned CNT_W = 8,
  localparam int unsigned DUTY_W = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [DUTY_W-1:0] duty_o
);
  localparam logic [DUTY_W-1:0] DUTY_FULL = {1'b1, {CNT_W{1'b0}}};

  logic [DUTY_W-1:0] duty_sat;
  logic [DUTY_W-1:0] duty_q;

  // over-range requests saturate to always-high
  assign duty_sat = (duty_i > DUTY_FULL) ? DUTY_FULL : duty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     duty_q <= '0;
    else if (load_i) duty_q <= duty_sat;
  end

  assign duty_o = duty_q;
endmodule

// File: rtl/pwm_cmp_reg.sv
module pwm_cmp_reg #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o
);
  logic gt_d;
  logic gt_q;

  assign gt_d = (a_i > b_i);

  // flop absorbs compare settling transients
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gt_q <= 1'b0;
    else         gt_q <= gt_d;
  end

  assign gt_o = gt_q;
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W:0]   duty_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned DUTY_W = CNT_W + 1;

  cnt_op_e           cnt_op;
  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic [DUTY_W-1:0] duty_q;
  logic [DUTY_W-1:0] cnt_ext;

  assign cnt_op = en_i ? CNT_INC : CNT_CLR;

  pwm_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (cnt_op),
    .ld_val_i ({CNT_W{1'b0}}),
    .cnt_o    (cnt),
    .at_max_o (wrap)
  );

  pwm_duty_latch #(.CNT_W(CNT_W)) i_duty (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wrap),
    .duty_i (duty_i),
    .duty_o (duty_q)
  );

  assign cnt_ext = {1'b0, cnt};

  pwm_cmp_reg #(.W(DUTY_W)) i_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (duty_q),
    .b_i    (cnt_ext),
    .gt_o   (pwm_o)
  );

  assign count_o = cnt;
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [CNT_W:0]   duty_q,
  input logic [CNT_W-1:0] count_o,
  input logic             pwm_o
);
  localparam logic [CNT_W:0] DUTY_FULL = {1'b1, {CNT_W{1'b0}}};

  // R1
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> count_o == CNT_W'($past(count_o) + 1'b1));

  // R2
  count_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> count_o == '0);

  // R3
  pwm_compare_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pwm_o == ($past(duty_q) > {1'b0, $past(count_o)}));

  // R5
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != {CNT_W{1'b1}}) |=> $stable(duty_q));

  // R6
  duty_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_q <= DUTY_FULL);

  // R7
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (pwm_o == 1'b0 && count_o == '0 && duty_q == '0);
    end
  end
endmodule

bind pwm_gen pwm_gen_chk #(.CNT_W(CNT_W)) i_pwm_gen_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .duty_q  (duty_q),
  .count_o (count_o),
  .pwm_o   (pwm_o)
);

// File: tb/test_pwm_gen.sv
module test_pwm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD_LEN = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [8:0] duty = '0;
  logic       pwm;
  logic [7:0] count;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_gen #(.CNT_W(8)) i_pwm_gen (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .en_i    (en),
    .duty_i  (duty),
    .pwm_o   (pwm),
    .count_o (count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected output at a sample showing count c: compare of c-1 (255 when c is 0)
  function automatic bit exp_pwm(input int d, input int c);
    int prev;
    prev = (c == 0) ? 255 : c - 1;
    return d > prev;
  endfunction

  // one full period starting at the sample where count_o == 1
  task automatic measure_period(input int d, input string req);
    int mism;
    int highs;
    mism  = 0;
    highs = 0;
    while (count != 8'd1) @(negedge clk);
    for (int i = 0; i < PERIOD_LEN; i++) begin
      if (pwm != exp_pwm(d, int'(count))) mism++;
      if (pwm) highs++;
      @(negedge clk);
    end
    chk(mism == 0, {req, " pattern mismatches"}, mism, 0);
    chk(highs == d, {req, " high cycles per period"}, highs, d);
  endtask

  // drive duty and wait until the wrap edge has captured it
  task automatic apply_duty(input int d);
    duty = 9'(d);
    @(negedge clk);
    while (count != 8'd0) @(negedge clk);
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0;
    en    = 1'b1;
    duty  = 9'd256;
    repeat (3) @(negedge clk);
    chk(pwm == 1'b0, "R7 pwm in reset", int'(pwm), 0);
    chk(count == 8'd0, "R7 count in reset", int'(count), 0);
  endtask

  task automatic t_first_period;
    rst_n = 1'b1;
    @(negedge clk);
    chk(count == 8'd1, "R1 first count after release", int'(count), 1);
    measure_period(0, "R8 first period ignores duty_i");
    measure_period(256, "R4 duty 256 always high");
  endtask

  task automatic t_count_wrap;
    int bad;
    int wraps;
    logic [7:0] prev;
    bad   = 0;
    wraps = 0;
    prev  = count;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (count != 8'(prev + 8'd1)) bad++;
      if (prev == 8'd255 && count == 8'd0) wraps++;
      prev = count;
    end
    chk(bad == 0, "R1 count step errors", bad, 0);
    chk(wraps == 1, "R1 wrap 255 to 0", wraps, 1);
  endtask

  task automatic t_duty_values;
    apply_duty(0);
    measure_period(0, "R4 duty 0 always low");
    apply_duty(255);
    measure_period(255, "R3 duty 255");
    apply_duty(64);
    measure_period(64, "R3 duty 64");
    apply_duty(300);
    measure_period(256, "R6 duty 300 saturates");
  endtask

  task automatic t_mid_change;
    int mism;
    apply_duty(200);
    while (count != 8'd100) @(negedge clk);
    duty = 9'd40;
    mism = 0;
    @(negedge clk);
    while (count != 8'd1) begin
      if (pwm != exp_pwm(200, int'(count))) mism++;
      @(negedge clk);
    end
    chk(mism == 0, "R5 rest of period keeps old duty", mism, 0);
    measure_period(40, "R5 new duty next period");
  endtask

  task automatic t_enable_low;
    while (count != 8'd50) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(count == 8'd0, "R2 count cleared", int'(count), 0);
    repeat (4) @(negedge clk);
    chk(count == 8'd0, "R2 count held at 0", int'(count), 0);
    chk(pwm == 1'b1, "R3 pwm while disabled duty 40 > 0", int'(pwm), 1);
    en = 1'b1;
    @(negedge clk);
    chk(count == 8'd1, "R2 resume at 1", int'(count), 1);
    @(negedge clk);
    chk(count == 8'd2, "R2 resume step", int'(count), 2);
  endtask

  task automatic t_reset_mid;
    while (count != 8'd10) @(negedge clk);
    chk(pwm == 1'b1, "R3 pwm high before reset", int'(pwm), 1);
    duty = 9'd128;
    #1 rst_n = 1'b0;
    #1;
    chk(pwm == 1'b0, "R7 async clear pwm", int'(pwm), 0);
    chk(count == 8'd0, "R7 async clear count", int'(count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    measure_period(0, "R8 first period after reset");
    measure_period(128, "R8 duty applied after first wrap");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_first_period();
    t_count_wrap();
    t_duty_values();
    t_mid_change();
    t_enable_low();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule